// File: doc/BRIEF.md
# Serially programmed clock fanout controller

This block is the digital control side of a one-to-ten clock fanout device. Two clock sources enter a selector, and the chosen clock is copied to ten output lanes. Each lane can be switched off. Clocks are modelled as single-ended logic levels, and each output is a purely combinational function of the selected source, so no register stage sits in the clock path.

A configuration word is loaded bit by bit. A serial data pin is sampled on the rising edges of a control clock while an active-low program pin is held low. The first eleven edges of a count shift bits in. The twelfth edge commits the 11-bit word to a control register, and the count then restarts. Bit 10 of the word selects the source, and bits 9..0 are the lane enables. The word is sent select bit first, then lane 9 down to lane 0.

Until a word has been committed after reset, every lane is on and the serial pin itself acts as the live source select. Each source carries a valid flag. When the selected source is flagged invalid, every enabled lane is forced high. There is no data stream here, so no valid/ready handshake is used and there is no back-pressure: all pins are plain levels.

Top module: `fanout_ctl_top`

## Requirements
- R1: On each rising `prog_clk` edge with `prog_n` low, among the first eleven edges of a count, `ser_in` is shifted into bit 0 of the shift register and the older bits move toward bit 10. As a result, the first bit sent lands in bit 10 (the select bit) and the last bit sent lands in bit 0 (lane 0 enable).
- R2: The word is committed to the control register on the twelfth counted edge, and not on any earlier edge. That edge shifts nothing and returns the count to zero.
- R3: Control bit i (i = 0..9) enables lane i. A lane whose bit is 0 drives a constant 0 on `fan_out[i]`.
- R4: Select bit value 0 picks `src_clk[0]` and value 1 picks `src_clk[1]`. Every enabled lane follows the chosen source combinationally.
- R5: From reset until the first commit, all ten lanes are enabled and the source select follows the live `ser_in` level.
- R6: While `prog_n` is high, `prog_clk` edges change neither the shift register, the count nor the control register. A word that is partly shifted resumes where it stopped.
- R7: If the valid flag (`src_ok`) of the selected source is 0, every enabled lane drives 1 and every disabled lane drives 0.
- R8: Asserting `rst_n` low asynchronously clears the shift register, the count and the committed flag, which returns the block to the R5 behaviour.
- R9: After a commit, `ser_in` has no effect on the source select.
- R10: Edges after a commit begin a new count. The next word therefore needs its own eleven shifts plus a commit edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_clk | input | 1 | Control clock for serial loading |
| prog_n | input | 1 | Active-low program enable; high freezes programming |
| ser_in | input | 1 | Serial word bit; acts as the live source select before the first commit |
| src_clk | input | 2 | Clock sources; index 0 and index 1 |
| src_ok | input | 2 | Per-source valid flag; 0 marks a failed source |
| fan_out | output | 10 | Output clock lanes |

## Verification
The checker evaluates on every cycle:
- that disabled lanes stay low and enabled lanes track the selected source or fail-safe high;
- that the live select is used before any commit;
- that the committed flag never falls without a reset;
- that a frozen program pin leaves the count and the control register untouched;
- that a commit occurs exactly when the count reaches its last value and leaves the count at zero.

Some properties can only be shown through the bench's scenarios, because they concern the content of the word rather than the timing of the commit. These include the bit order in which a word lands in the control register, a word resuming correctly after a freeze, a reset in the middle of a word discarding the partial bits, and a second word needing a full count of its own.

// File: rtl/fo_pkg.sv
package fo_pkg;
  localparam int unsigned FO_LANES = 10;
  localparam int unsigned FO_SRCS  = 2;

  typedef enum logic {
    SRC_ZERO = 1'b0,
    SRC_ONE  = 1'b1
  } src_sel_e;

  function automatic logic lane_level(input logic lane_on,
                                      input logic src_level,
                                      input logic src_valid);
    if (!lane_on)        return 1'b0;
    else if (!src_valid) return 1'b1;
    else                 return src_level;
  endfunction
endpackage

// File: rtl/fo_serial_loader.sv
module fo_serial_loader #(
  parameter int unsigned WORD = 11,
  localparam int unsigned LAST = WORD,
  localparam int unsigned CW = $clog2(WORD + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prog_n,
  input  logic            ser_in,
  output logic [WORD-1:0] word,
  output logic [CW-1:0]   count,
  output logic            commit
);
  // The count runs 0..WORD; the edge seen at count == WORD is the commit edge.
  assign commit = !prog_n && (count == CW'(LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '0;
      count <= '0;
    end else if (!prog_n) begin
      if (count == CW'(LAST)) begin
        count <= '0;
      end else begin
        word  <= {word[WORD-2:0], ser_in};
        count <= count + CW'(1);
      end
    end
  end
endmodule

// File: rtl/fo_ctrl_reg.sv
module fo_ctrl_reg #(
  parameter int unsigned WORD = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit,
  input  logic [WORD-1:0] word_in,
  output logic [WORD-1:0] ctrl,
  output logic            committed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      committed <= 1'b0;
    end else if (commit) begin
      ctrl      <= word_in;
      committed <= 1'b1;
    end
  end
endmodule

// File: rtl/fo_src_select.sv
module fo_src_select #(
  parameter int unsigned NSRC = 2,
  localparam int unsigned SW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] src_clk,
  input  logic [NSRC-1:0] src_ok,
  input  logic [SW-1:0]   sel,
  output logic            clk_sel,
  output logic            sel_ok
);
  always_comb begin
    clk_sel = 1'b0;
    sel_ok  = 1'b0;
    for (int s = 0; s < NSRC; s++) begin
      if (sel == SW'(s)) begin
        clk_sel = src_clk[s];
        sel_ok  = src_ok[s];
      end
    end
  end
endmodule

// File: rtl/fo_out_gate.sv
module fo_out_gate
  import fo_pkg::*;
#(
  parameter int unsigned LANES = 10
) (
  input  logic [LANES-1:0] lane_en,
  input  logic             clk_sel,
  input  logic             sel_ok,
  output logic [LANES-1:0] lane_out
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_out[g] = lane_level(lane_en[g], clk_sel, sel_ok);
  end
endmodule

// File: rtl/fanout_ctl_top.sv
module fanout_ctl_top
  import fo_pkg::*;
#(
  parameter int unsigned LANES = FO_LANES,
  localparam int unsigned WORD = LANES + 1,
  localparam int unsigned CW = $clog2(WORD + 1)
) (
  input  logic             rst_n,
  input  logic             prog_clk,
  input  logic             prog_n,
  input  logic             ser_in,
  input  logic [1:0]       src_clk,
  input  logic [1:0]       src_ok,
  output logic [LANES-1:0] fan_out
);
  logic [WORD-1:0]  shift_word;
  logic [CW-1:0]    count;
  logic             commit;
  logic [WORD-1:0]  ctrl;
  logic             committed;
  src_sel_e         sel_eff;
  logic [LANES-1:0] en_eff;
  logic             clk_sel;
  logic             sel_ok;

  fo_serial_loader #(.WORD(WORD)) u_loader (
    .clk    (prog_clk),
    .rst_n  (rst_n),
    .prog_n (prog_n),
    .ser_in (ser_in),
    .word   (shift_word),
    .count  (count),
    .commit (commit)
  );

  fo_ctrl_reg #(.WORD(WORD)) u_ctrl (
    .clk       (prog_clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .word_in   (shift_word),
    .ctrl      (ctrl),
    .committed (committed)
  );

  // Before any commit: all lanes on, live serial pin selects the source.
  always_comb begin
    if (committed) begin
      sel_eff = src_sel_e'(ctrl[WORD-1]);
      en_eff  = ctrl[LANES-1:0];
    end else begin
      sel_eff = src_sel_e'(ser_in);
      en_eff  = '1;
    end
  end

  fo_src_select #(.NSRC(FO_SRCS)) u_sel (
    .src_clk (src_clk),
    .src_ok  (src_ok),
    .sel     (sel_eff),
    .clk_sel (clk_sel),
    .sel_ok  (sel_ok)
  );

  fo_out_gate #(.LANES(LANES)) u_gate (
    .lane_en  (en_eff),
    .clk_sel  (clk_sel),
    .sel_ok   (sel_ok),
    .lane_out (fan_out)
  );
endmodule

// File: rtl/fo_checker.sv
module fo_checker #(
  parameter int unsigned LANES = 10,
  parameter int unsigned WORD = 11,
  parameter int unsigned CW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prog_n,
  input logic             ser_in,
  input logic [CW-1:0]    count,
  input logic [WORD-1:0]  ctrl,
  input logic             committed,
  input logic             sel_eff,
  input logic [LANES-1:0] en_eff,
  input logic             clk_sel,
  input logic             sel_ok,
  input logic [LANES-1:0] fan_out
);
  always_comb begin
    if (rst_n) begin
      assert_disabled_low_R3: assert ((fan_out & ~en_eff) == '0);
      if (sel_ok) begin
        assert_follow_src_R4: assert (fan_out == (en_eff & {LANES{clk_sel}}));
      end else begin
        assert_failsafe_high_R7: assert (fan_out == en_eff);
      end
      if (!committed) begin
        assert_live_select_R5: assert (sel_eff == ser_in && en_eff == '1);
      end
    end
  end

  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(prog_n) |-> ($stable(count) && $stable(ctrl)));

  assert_commit_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(prog_n) && $past(count) == CW'(WORD)) |-> (count == '0 && committed));

  assert_sticky_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(committed) |-> committed);

  assert_count_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(WORD));
endmodule

bind fanout_ctl_top fo_checker #(.LANES(LANES), .WORD(WORD), .CW(CW)) u_chk (
  .clk       (prog_clk),
  .rst_n     (rst_n),
  .prog_n    (prog_n),
  .ser_in    (ser_in),
  .count     (count),
  .ctrl      (ctrl),
  .committed (committed),
  .sel_eff   (sel_eff),
  .en_eff    (en_eff),
  .clk_sel   (clk_sel),
  .sel_ok    (sel_ok),
  .fan_out   (fan_out)
);

// File: tb/sim_fanout_ctl_top.sv
module sim_fanout_ctl_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 20000;

  logic       rst_n = 1'b0;
  logic       prog_clk = 1'b0;
  logic       prog_n = 1'b1;
  logic       ser_in = 1'b0;
  logic [1:0] src_clk = 2'b01;
  logic [1:0] src_ok = 2'b11;
  logic [9:0] fan_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic [9:0] exp_q[$];
  string      tag_q[$];
  event       chk_ev;

  fanout_ctl_top u0 (
    .rst_n(rst_n), .prog_clk(prog_clk), .prog_n(prog_n), .ser_in(ser_in),
    .src_clk(src_clk), .src_ok(src_ok), .fan_out(fan_out)
  );

  always #(CLK_PERIOD/2) prog_clk = ~prog_clk;

  // Monitor: pops expected items and compares with the ports.
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        logic [9:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_checks++;
        if (fan_out !== e) begin
          n_fail++;
          $display("FAIL %s: fan_out=%h expected=%h", t, fan_out, e);
        end
      end
    end
  end

  task automatic expect_out(input logic [9:0] e, input string t);
    #1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    ->chk_ev;
    #1;
  endtask

  // Shift n bits of w, starting at position 'from' counted from bit 10.
  task automatic shift_bits(input logic [10:0] w, input int from, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge prog_clk);
      prog_n = 1'b0;
      ser_in = w[10-(from+k)];
    end
    @(negedge prog_clk);
    prog_n = 1'b1;
  endtask

  task automatic commit_edge();
    @(negedge prog_clk);
    prog_n = 1'b0;
    ser_in = 1'b0;
    @(negedge prog_clk);
    prog_n = 1'b1;
  endtask

  task automatic idle_edges(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge prog_clk);
      ser_in = ~ser_in;
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYC);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R8 / R5: reset state, all lanes on, live select = 0 -> src 0 (high)
    #3;
    expect_out(10'h3FF, "R8 reset all lanes on");
    @(negedge prog_clk);
    rst_n = 1'b1;
    ser_in = 1'b1;
    expect_out(10'h000, "R5 live select picks src 1");
    src_ok = 2'b01;
    expect_out(10'h3FF, "R7 failed src 1 drives high");
    src_ok = 2'b11;

    // R1 / R4: word sel=1, lanes 0x2A5
    shift_bits(11'b1_1010100101, 0, 11);
    commit_edge();
    src_clk = 2'b10;
    expect_out(10'h2A5, "R1 R3 committed lanes follow src 1");
    src_clk = 2'b00;
    expect_out(10'h000, "R4 src 1 low");
    src_clk = 2'b01;
    expect_out(10'h000, "R4 src 0 ignored when select=1");
    src_clk = 2'b10;
    ser_in = 1'b0;
    expect_out(10'h2A5, "R9 ser_in no longer selects");
    src_ok = 2'b01;
    src_clk = 2'b00;
    expect_out(10'h2A5, "R7 enabled lanes high, disabled low");
    src_ok = 2'b11;

    // R6: frozen edges change nothing
    idle_edges(20);
    src_clk = 2'b10;
    expect_out(10'h2A5, "R6 frozen edges ignored");

    // R6 / R2: partial word, freeze, resume; word sel=0 lanes 0x00F
    shift_bits(11'b0_0000001111, 0, 5);
    idle_edges(4);
    shift_bits(11'b0_0000001111, 5, 6);
    src_clk = 2'b10;
    expect_out(10'h2A5, "R2 no commit after 11 shifts");
    commit_edge();
    src_clk = 2'b01;
    expect_out(10'h00F, "R6 resumed word committed");

    // R10: next word needs a full count of its own; word 0x578
    shift_bits(11'b1_0101111000, 0, 11);
    src_clk = 2'b01;
    expect_out(10'h00F, "R10 new count not committed early");
    commit_edge();
    src_clk = 2'b10;
    expect_out(10'h178, "R10 second word committed");

    // R8: reset mid-word discards partial bits and the commit
    shift_bits(11'b1_1111111111, 0, 4);
    #2;
    rst_n = 1'b0;
    ser_in = 1'b0;
    src_clk = 2'b01;
    expect_out(10'h3FF, "R8 reset returns to live mode");
    @(negedge prog_clk);
    rst_n = 1'b1;
    shift_bits(11'b0_1111110000, 0, 11);
    ser_in = 1'b0;
    expect_out(10'h3FF, "R8 count restarted from zero");
    commit_edge();
    ser_in = 1'b1;
    expect_out(10'h3F0, "R1 R3 bit order after reset");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule